// File: doc/BRIEF.md
# Base Address Window Decoder

This block holds the base address registers of one bus device: six regular windows and one expansion-ROM window, together with the two command enables (I/O space and memory space). Each window has a power-of-two size and a type, I/O or memory, and both are fixed by parameters. A configuration write strobe loads a base register or the command register. An incoming lookup carries an address and a flag that says whether it targets I/O space or memory space. The block reports which windows claim that address, a single winning window index, and the offset of the address inside the winning window.

A window takes part in decoding only when all of these hold: its base is aligned, its base is nonzero, it does not run past the top of the address space, its space enable is set in the command register and, for an I/O window, its last address lies below 0x10000. The ROM window also needs the enable bit held in bit 0 of its own register. The decode path is purely combinational from the lookup inputs. The lookup has no ready signal and never applies back-pressure: every cycle with `req_valid` high is answered in that same cycle. Configuration writes take effect on the next clock edge.

Top module: `bar_window_decode`

## Requirements
- R1: After reset, all base registers and both command enables are zero, so no window hits for any lookup.
- R2: A base write keeps only the bits at or above the window size (`cfg_wdata & ~(size-1)`), so low bits written into a base register do not move the window.
- R3: A valid window hits when `req_addr & ~(size-1)` equals its base and `req_is_io` matches its type; `hit_offset` is then `req_addr & (size-1)` of the winning window.
- R4: `cfg_sel` = 7 writes the command register, where bit 0 enables the I/O windows and bit 1 enables the memory windows (ROM included). A window whose space enable is clear never hits.
- R5: A window whose masked base is zero, or whose last address would pass the top of the address space, never hits.
- R6: An I/O window whose last address is 0x10000 or higher never hits.
- R7: `cfg_sel` = 6 writes the ROM window. It hits only while bit 0 of the written value is 1, and that bit is kept apart from the base.
- R8: A window configured with size code 0 (absent) never hits, whatever is written to it.
- R9: When several windows hit, `hit_idx` names the lowest-numbered one and `multi_hit` is 1. `multi_hit` is 0 when at most one window hits. `hit_any` is 1 exactly when some window hits.
- R10: With `req_valid` low, no window hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Target: 0..NUM_BARS-1 regular windows, NUM_BARS ROM, NUM_BARS+1 command |
| cfg_wdata | input | ADDR_W | Write value |
| req_valid | input | 1 | Lookup present |
| req_addr | input | ADDR_W | Lookup address |
| req_is_io | input | 1 | 1 = I/O space lookup, 0 = memory space |
| region_hit | output | NUM_BARS+1 | Per-window hit, bit NUM_BARS = ROM |
| hit_any | output | 1 | Some window hits |
| hit_idx | output | SEL_W | Lowest-numbered hitting window |
| hit_offset | output | ADDR_W | Offset inside the winning window |
| multi_hit | output | 1 | More than one window hits |

## Verification
For every window, the bench probes four addresses: one below the base, the base itself, the last byte of the window, and the first byte past it. Each probe is tried in both spaces, so it separates an off-by-one in the mask from a type mix-up. These sweeps run with the command register set in each of its four states, and then again after the ROM enable is set, after an I/O window is moved from past the 64K limit to below it, and after a base is cleared to zero. One window is placed inside another so that the same sweep also checks the priority and the conflict flag. A final pass repeats the sweep with `req_valid` low.

// File: rtl/bar_decode_pkg.sv
package bar_decode_pkg;
  localparam int CMD_IO_BIT  = 0;
  localparam int CMD_MEM_BIT = 1;
  localparam int SZ_FIELD_W  = 8;
  localparam int IO_TOP_LOG  = 16;
endpackage

// File: rtl/bar_region_slot.sv
module bar_region_slot #(
  parameter int ADDR_W = 20,
  parameter int SZ_LOG = 4,
  parameter bit IS_IO  = 1'b0,
  parameter bit IS_ROM = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              io_en,
  input  logic              mem_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_io,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  import bar_decode_pkg::*;

  localparam bit PRESENT = (SZ_LOG > 0) && (SZ_LOG < ADDR_W);
  localparam logic [ADDR_W-1:0] LOW =
    PRESENT ? ADDR_W'((64'd1 << SZ_LOG) - 64'd1) : '0;

  logic [ADDR_W-1:0] base_q, base_eff;
  logic [ADDR_W:0]   last_addr;
  logic              space_on, rom_on, io_ok, usable;

  always_ff @(posedge clk) begin
    if (!rst_n)
      base_q <= '0;
    else if (wr_en)
      base_q <= PRESENT ? ((wdata & ~LOW) |
                           (IS_ROM ? {{(ADDR_W-1){1'b0}}, wdata[0]} : '0))
                        : '0;
  end

  always_comb begin
    base_eff  = base_q & ~LOW;
    last_addr = {1'b0, base_eff} + {1'b0, LOW};
    io_ok     = IS_IO ? (last_addr[ADDR_W:IO_TOP_LOG] == '0) : 1'b1;
    space_on  = IS_IO ? io_en : mem_en;
    rom_on    = IS_ROM ? base_q[0] : 1'b1;
    usable    = PRESENT && (base_eff != '0) && !last_addr[ADDR_W] &&
                io_ok && space_on && rom_on;
    hit       = req_valid && usable && (req_is_io == IS_IO) &&
                ((req_addr & ~LOW) == base_eff);
    offset    = req_addr & LOW;
  end
endmodule

// File: rtl/bar_hit_pick.sv
module bar_hit_pick #(
  parameter int N      = 7,
  parameter int ADDR_W = 20,
  parameter int SEL_W  = 3
) (
  input  logic [N-1:0]             hits,
  input  logic [N-1:0][ADDR_W-1:0] offs,
  output logic                     any,
  output logic [SEL_W-1:0]         idx,
  output logic [ADDR_W-1:0]        off,
  output logic                     conflict
);
  always_comb begin
    idx = '0;
    off = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hits[k]) begin
        idx = SEL_W'(k);
        off = offs[k];
      end
    end
    any      = |hits;
    conflict = (hits & (hits - N'(1))) != '0;
  end
endmodule

// File: rtl/bar_window_decode.sv
module bar_window_decode #(
  parameter int ADDR_W   = 20,
  parameter int NUM_BARS = 6,
  parameter logic [NUM_BARS*8-1:0] REG_SZ_LOG = {8'd4, 8'd0, 8'd16, 8'd8, 8'd12, 8'd4},
  parameter logic [NUM_BARS-1:0]   REG_IS_IO  = 6'b000101,
  parameter int ROM_SZ_LOG = 11,
  localparam int SEL_W = $clog2(NUM_BARS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_io,
  output logic [NUM_BARS:0] region_hit,
  output logic              hit_any,
  output logic [SEL_W-1:0]  hit_idx,
  output logic [ADDR_W-1:0] hit_offset,
  output logic              multi_hit
);
  import bar_decode_pkg::*;

  localparam int NREG = NUM_BARS + 1;
  localparam logic [SEL_W-1:0] CMD_SEL = SEL_W'(NUM_BARS + 1);

  logic [1:0] cmd_q;
  logic [NREG-1:0][ADDR_W-1:0] offs;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cmd_q <= 2'b00;
    else if (cfg_wr && cfg_sel == CMD_SEL)
      cmd_q <= {cfg_wdata[CMD_MEM_BIT], cfg_wdata[CMD_IO_BIT]};
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam bit ROMSLOT = (g == NUM_BARS);
    localparam int SZL = ROMSLOT ? ROM_SZ_LOG
                                 : int'(REG_SZ_LOG[(ROMSLOT ? 0 : g)*8 +: 8]);
    localparam bit IOSLOT = ROMSLOT ? 1'b0 : REG_IS_IO[ROMSLOT ? 0 : g];
    bar_region_slot #(
      .ADDR_W(ADDR_W), .SZ_LOG(SZL), .IS_IO(IOSLOT), .IS_ROM(ROMSLOT)
    ) slot_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr && cfg_sel == SEL_W'(g)),
      .wdata(cfg_wdata),
      .io_en(cmd_q[0]), .mem_en(cmd_q[1]),
      .req_valid(req_valid), .req_addr(req_addr), .req_is_io(req_is_io),
      .hit(region_hit[g]), .offset(offs[g])
    );
  end

  bar_hit_pick #(.N(NREG), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) pick_i (
    .hits(region_hit), .offs(offs),
    .any(hit_any), .idx(hit_idx), .off(hit_offset), .conflict(multi_hit)
  );
endmodule

// File: rtl/bar_decode_checker.sv
module bar_decode_checker #(
  parameter int NUM_BARS = 6,
  parameter int SEL_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [SEL_W-1:0]  cfg_sel,
  input logic [1:0]        cfg_cmd,
  input logic              req_valid,
  input logic [NUM_BARS:0] region_hit,
  input logic              hit_any,
  input logic [SEL_W-1:0]  hit_idx,
  input logic              multi_hit
);
  localparam logic [SEL_W-1:0] CMD_SEL = SEL_W'(NUM_BARS + 1);

  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> region_hit == '0); // R10
  AST_WINNER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> region_hit[hit_idx]); // R9
  AST_WINNER_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (region_hit & ((NUM_BARS+1)'(1) << hit_idx) - (NUM_BARS+1)'(1)) == '0); // R9
  AST_CONFLICT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit == ($countones(region_hit) > 1)); // R9
  AST_ANY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any == (region_hit != '0)); // R9
  AST_CMD_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == CMD_SEL && cfg_cmd == 2'b00) |=> region_hit == '0); // R4
endmodule

bind bar_window_decode bar_decode_checker #(.NUM_BARS(NUM_BARS), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_cmd(cfg_wdata[1:0]), .req_valid(req_valid), .region_hit(region_hit),
  .hit_any(hit_any), .hit_idx(hit_idx), .multi_hit(multi_hit)
);

// File: tb/bar_window_decode_tb_top.sv
module bar_window_decode_tb_top;
  localparam int AW = 20;
  localparam int NB = 6;
  localparam int SW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [SW-1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_is_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [NB:0] region_hit;
  logic hit_any, multi_hit;
  logic [SW-1:0] hit_idx;
  logic [AW-1:0] hit_offset;

  int n_run = 0, n_fail = 0;
  int szl [7] = '{4, 12, 8, 16, 0, 4, 11};
  bit isio [7] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  longint bval [7] = '{0, 0, 0, 0, 0, 0, 0};
  logic [1:0] cmd = 2'b00;

  always #10 clk = ~clk;

  bar_window_decode #(.ADDR_W(AW), .NUM_BARS(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_io(req_is_io), .region_hit(region_hit), .hit_any(hit_any),
    .hit_idx(hit_idx), .hit_offset(hit_offset), .multi_hit(multi_hit)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hit(int i, longint a, bit io);
    longint sz, b;
    if (!req_valid || szl[i] == 0) return 1'b0;
    sz = longint'(1) << szl[i];
    b = bval[i] & ~(sz - 1);
    if (b == 0 || b + sz > (longint'(1) << AW)) return 1'b0;
    if (isio[i] && b + sz - 1 >= 'h10000) return 1'b0;
    if (isio[i] ? !cmd[0] : !cmd[1]) return 1'b0;
    if (i == 6 && bval[6][0] == 1'b0) return 1'b0;
    if (io != isio[i]) return 1'b0;
    return (a & ~(sz - 1)) == b;
  endfunction

  task automatic cfg_write(int sel, longint v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = SW'(sel); cfg_wdata = AW'(v);
    @(negedge clk);
    cfg_wr = 1'b0;
    if (sel == 7) cmd = v[1:0];
    else if (sel < 7) bval[sel] = v & ((longint'(1) << AW) - 1);
  endtask

  task automatic probe(string tag, longint a, bit io);
    logic [NB:0] ev;
    int win;
    @(negedge clk);
    req_addr = AW'(a); req_is_io = io;
    #2;
    ev = '0; win = -1;
    for (int i = 6; i >= 0; i--) begin
      ev[i] = exp_hit(i, a & ((longint'(1) << AW) - 1), io);
      if (ev[i]) win = i;
    end
    chk({tag, " hit vector"}, region_hit, ev);
    chk("R9 multi_hit", multi_hit, $countones(ev) > 1);
    chk("R9 hit_any", hit_any, ev != '0);
    if (win >= 0) begin
      chk("R9 hit_idx", hit_idx, win);
      chk("R3 hit_offset", hit_offset, a & ((longint'(1) << szl[win]) - 1));
    end
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 7; i++) begin
      longint sz = longint'(1) << (szl[i] == 0 ? 4 : szl[i]);
      longint b = bval[i] & ~(sz - 1);
      for (int io = 0; io < 2; io++) begin
        probe(tag, b - 1, io[0]);
        probe(tag, b, io[0]);
        probe(tag, b + sz - 1, io[0]);
        probe(tag, b + sz, io[0]);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b1;
    probe("R1 reset", 'h0, 1'b0);
    probe("R1 reset", 'h1234, 1'b1);
    cfg_write(0, 'h1234F);
    cfg_write(0, 'h123F);
    cfg_write(1, 'h45678);
    cfg_write(2, 'hFFF00);
    cfg_write(3, 'h30000);
    cfg_write(4, 'hAAAA0);
    cfg_write(5, 'h45010);
    cfg_write(6, 'h80000);
    sweep("R4 cmd off");
    cfg_write(7, 'h1);
    sweep("R4 io only");
    cfg_write(7, 'h2);
    sweep("R4 mem only");
    cfg_write(7, 'h3);
    sweep("R2 R6 R7 R8 both on");
    probe("R8 absent window", 'hAAAA0, 1'b0);
    cfg_write(6, 'h80001);
    sweep("R7 rom enabled");
    probe("R7 rom offset", 'h807FF, 1'b0);
    cfg_write(2, 'h0FF00);
    sweep("R6 io below limit");
    cfg_write(0, 'h5);
    sweep("R5 zero base");
    probe("R3 overlap", 'h4501F, 1'b0);
    req_valid = 1'b0;
    sweep("R10 idle");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #3000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule